// File: doc/BRIEF.md
# Dual-Channel Converter Output Formatter

This block is the digital back end of a two-channel, 10-bit sampling converter. In each conversion period a stimulus interface presents one pair of codes, one for channel A and one for channel B, both taken at the same instant. The block holds each pair for a mode-dependent number of clock cycles. It then presents the pair either on two parallel 10-bit buses or interleaved on one shared bus. It also produces a complementary pair of latch clocks that a downstream receiver uses to capture the words.

Two configuration inputs select one of four arrangements. With `modeSel`=0 or `singleBus`=1 the input clock runs at twice the per-channel rate. An internal phase bit then takes a new pair on every second rising edge, the first edge after reset being a sample edge. With `modeSel`=1 and `singleBus`=0, every rising edge takes a pair. An active-low output enable and an active-high standby input both release the outputs without waiting for a clock. Each tri-stated output is modelled as a value plus a drive-enable. A released value reads as zero.

Top module: `dualCodeFmt`

## Requirements
- R1: While `rstN` is low at a rising edge, the phase bit, the latch divider and every held code are cleared. After that edge both buses read 0, `latchClk` reads 0 and `latchClkN` reads 1.
- R2: With `modeSel`=0 and `singleBus`=0, a pair is taken on every second edge, starting with the first edge after reset. A pair taken at edge k appears unchanged on `busA` (channel A) and `busB` (channel B) after edge k+8 and stays through edge k+9. Codes are 10-bit unsigned with bit 9 as MSB (3FFh, 200h and 000h pass bit-exact).
- R3: With `modeSel`=1 and `singleBus`=0, a pair is taken on every edge. A pair taken at edge k appears on `busA`/`busB` after edge k+4.
- R4: With `singleBus`=1, pairs are taken on every second edge. The A code taken at edge k is on `busA` after edge k+8. The B code of the same pair is on `busA` after edge k+9. The bus alternates A, B, A, B.
- R5: With `singleBus`=1, `busBEn` is 0 and `busB` reads 0. With `singleBus`=0 and the outputs enabled, `busBEn` is 1.
- R6: With `modeSel`=1 and `singleBus`=1, `latchClk` is 1 exactly when `busA` carries a channel-A word, so it alternates every cycle.
- R7: In the other three arrangements, `latchClk` toggles once for every pair taken.
- R8: Whenever `latchEn` is 1, `latchClkN` is the exact inverse of `latchClk`. When `latchEn` is 0, both read 0.
- R9: `outEnN`=1 clears `busAEn`, `busBEn` and `latchEn` at once, without a clock edge, and zeroes the bus values. `outEnN`=0 restores them at once.
- R10: `standby`=1 clears `busAEn`, `busBEn` and `latchEn` at once, regardless of `outEnN`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Converter clock |
| rstN | input | 1 | Synchronous active-low reset |
| modeSel | input | 1 | Clock-rate / latch-rate select |
| singleBus | input | 1 | 1 = interleave both channels on bus A |
| outEnN | input | 1 | Active-low output enable, asynchronous |
| standby | input | 1 | 1 = release all outputs |
| codeA | input | 10 | Channel A code of the current pair |
| codeB | input | 10 | Channel B code of the current pair |
| busA | output | 10 | Primary data bus value |
| busAEn | output | 1 | Primary bus drive-enable |
| busB | output | 10 | Secondary data bus value |
| busBEn | output | 1 | Secondary bus drive-enable |
| latchClk | output | 1 | Output latch clock value |
| latchClkN | output | 1 | Complementary latch clock value |
| latchEn | output | 1 | Drive-enable of both latch clocks |

## Verification
A phase bit that starts on the wrong value would take pairs on the off edges. It would also swap A and B words on the shared bus, and this would show as a mismatch on `busA` at the first filled pipeline slot, eight or nine cycles after reset. A tap set to the wrong depth shifts every word by whole cycles, so the first non-zero word arrives early or late against the expected edge. Latch divider or enable faults show in the very first cycle after reset, on `latchClk` and on the enables.

// File: rtl/dualCodeFmtPkg.sv
package dualCodeFmtPkg;
  typedef struct packed {
    logic takeSample;
    logic phaseHi;
    logic singleBus;
    logic fastClk;
    logic driveA;
    logic driveB;
  } fmtCtl_t;
endpackage

// File: rtl/fmtDelayLine.sv
module fmtDelayLine #(
  parameter int W     = 10,
  parameter int DEPTH = 10,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             load,
  input  logic [W-1:0]     din,
  input  logic [IDX_W-1:0] tapSel,
  output logic [W-1:0]     tap
);
  logic [W-1:0] stage [DEPTH];

  // stage[0] captures on the sample strobe; later stages shift every edge
  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < DEPTH; i++) stage[i] <= '0;
    end else begin
      if (load) stage[0] <= din;
      for (int i = 1; i < DEPTH; i++) stage[i] <= stage[i-1];
    end
  end

  assign tap = stage[tapSel];
endmodule

// File: rtl/dualCodeFmtCtrl.sv
module dualCodeFmtCtrl
  import dualCodeFmtPkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    modeSel,
  input  logic    singleBus,
  input  logic    outEnN,
  input  logic    standby,
  output fmtCtl_t ctl,
  output logic    latchClk,
  output logic    latchClkN,
  output logic    latchEn
);
  logic phase;
  logic latchDiv;
  logic fastClk;
  logic takeSample;
  logic latchLvl;
  logic driveOn;

  assign fastClk    = !(modeSel && !singleBus);
  assign takeSample = fastClk ? !phase : 1'b1;

  always_ff @(posedge clk) begin
    if (!rstN) phase <= 1'b0;
    else       phase <= ~phase;
  end

  always_ff @(posedge clk) begin
    if (!rstN)          latchDiv <= 1'b0;
    else if (takeSample) latchDiv <= ~latchDiv;
  end

  // fast latch clock marks the channel on the shared bus
  assign latchLvl = (modeSel && singleBus) ? phase : latchDiv;
  assign driveOn  = !outEnN && !standby;

  assign latchEn   = driveOn;
  assign latchClk  = driveOn &  latchLvl;
  assign latchClkN = driveOn & ~latchLvl;

  always_comb begin
    ctl.takeSample = takeSample;
    ctl.phaseHi    = phase;
    ctl.singleBus  = singleBus;
    ctl.fastClk    = fastClk;
    ctl.driveA     = driveOn;
    ctl.driveB     = driveOn && !singleBus;
  end
endmodule

// File: rtl/dualCodeFmtPath.sv
module dualCodeFmtPath
  import dualCodeFmtPkg::*;
#(
  parameter int CODE_W   = 10,
  parameter int LAT_FAST = 8,
  parameter int LAT_SLOW = 4,
  parameter int B_LAG    = 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  fmtCtl_t           ctl,
  input  logic [CODE_W-1:0] codeA,
  input  logic [CODE_W-1:0] codeB,
  output logic [CODE_W-1:0] busA,
  output logic [CODE_W-1:0] busB
);
  localparam int DEPTH = LAT_FAST + B_LAG + 1;
  localparam int IDX_W = $clog2(DEPTH);
  localparam int NCH   = 2;

  logic [IDX_W-1:0] latA;
  logic [IDX_W-1:0] latB;
  logic [NCH-1:0][CODE_W-1:0] chIn;
  logic [NCH-1:0][CODE_W-1:0] chTap;
  logic [NCH-1:0][IDX_W-1:0]  chSel;
  logic [CODE_W-1:0] aWord;

  always_comb begin
    latA = ctl.fastClk ? IDX_W'(LAT_FAST) : IDX_W'(LAT_SLOW);
    latB = ctl.singleBus ? latA + IDX_W'(B_LAG) : latA;
  end

  assign chIn  = {codeB, codeA};
  assign chSel = {latB, latA};

  generate
    for (genvar c = 0; c < NCH; c++) begin : g_ch
      fmtDelayLine #(.W(CODE_W), .DEPTH(DEPTH)) u_line (
        .clk    (clk),
        .rstN   (rstN),
        .load   (ctl.takeSample),
        .din    (chIn[c]),
        .tapSel (chSel[c]),
        .tap    (chTap[c])
      );
    end
  endgenerate

  // shared bus: A word while phase is high, B word (one cycle later) otherwise
  assign aWord = ctl.singleBus ? (ctl.phaseHi ? chTap[0] : chTap[1]) : chTap[0];
  assign busA  = ctl.driveA ? aWord    : '0;
  assign busB  = ctl.driveB ? chTap[1] : '0;
endmodule

// File: rtl/dualCodeFmt.sv
module dualCodeFmt
  import dualCodeFmtPkg::*;
#(
  parameter int CODE_W   = 10,
  parameter int LAT_FAST = 8,
  parameter int LAT_SLOW = 4,
  parameter int B_LAG    = 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              modeSel,
  input  logic              singleBus,
  input  logic              outEnN,
  input  logic              standby,
  input  logic [CODE_W-1:0] codeA,
  input  logic [CODE_W-1:0] codeB,
  output logic [CODE_W-1:0] busA,
  output logic              busAEn,
  output logic [CODE_W-1:0] busB,
  output logic              busBEn,
  output logic              latchClk,
  output logic              latchClkN,
  output logic              latchEn
);
  fmtCtl_t ctl;

  dualCodeFmtCtrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .modeSel   (modeSel),
    .singleBus (singleBus),
    .outEnN    (outEnN),
    .standby   (standby),
    .ctl       (ctl),
    .latchClk  (latchClk),
    .latchClkN (latchClkN),
    .latchEn   (latchEn)
  );

  dualCodeFmtPath #(
    .CODE_W   (CODE_W),
    .LAT_FAST (LAT_FAST),
    .LAT_SLOW (LAT_SLOW),
    .B_LAG    (B_LAG)
  ) u_path (
    .clk   (clk),
    .rstN  (rstN),
    .ctl   (ctl),
    .codeA (codeA),
    .codeB (codeB),
    .busA  (busA),
    .busB  (busB)
  );

  assign busAEn = ctl.driveA;
  assign busBEn = ctl.driveB;
endmodule

// File: rtl/dualCodeFmtChecker.sv
module dualCodeFmtChecker (
  input logic clk,
  input logic rstN,
  input logic modeSel,
  input logic singleBus,
  input logic outEnN,
  input logic standby,
  input logic busAEn,
  input logic busBEn,
  input logic latchEn,
  input logic latchClk,
  input logic latchClkN
);
  // R8
  latch_compl_chk: assert property (@(posedge clk) disable iff (!rstN)
    latchEn |-> (latchClk == !latchClkN));

  // R8
  latch_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    !latchEn |-> (!latchClk && !latchClkN));

  // R5
  busb_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    singleBus |-> !busBEn);

  // R9
  oe_release_chk: assert property (@(posedge clk) disable iff (!rstN)
    outEnN |-> (!busAEn && !busBEn && !latchEn));

  // R10
  stby_release_chk: assert property (@(posedge clk) disable iff (!rstN)
    standby |-> (!busAEn && !busBEn && !latchEn));

  // R6
  latch_alt_chk: assert property (@(posedge clk) disable iff (!rstN)
    (modeSel && singleBus && latchEn &&
     $past(rstN) && $past(modeSel && singleBus && latchEn))
    |-> (latchClk != $past(latchClk)));
endmodule

bind dualCodeFmt dualCodeFmtChecker u_chk (.*);

// File: tb/dualCodeFmt_bench.sv
module dualCodeFmt_bench;
  localparam int CW = 10;
  localparam logic [2*CW-1:0] VEC [8] = '{
    {10'h3FF, 10'h000}, {10'h200, 10'h200}, {10'h000, 10'h3FF}, {10'h155, 10'h2AA},
    {10'h001, 10'h3FE}, {10'h123, 10'h321}, {10'h2AA, 10'h155}, {10'h0F0, 10'h30F}
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic modeSel = 1'b0, singleBus = 1'b0, outEnN = 1'b0, standby = 1'b0;
  logic [CW-1:0] codeA = '0, codeB = '0;
  logic [CW-1:0] busA, busB;
  logic busAEn, busBEn, latchClk, latchClkN, latchEn;
  int nChecks = 0;
  int nFails = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  dualCodeFmt u_dualCodeFmt (
    .clk(clk), .rstN(rstN), .modeSel(modeSel), .singleBus(singleBus),
    .outEnN(outEnN), .standby(standby), .codeA(codeA), .codeB(codeB),
    .busA(busA), .busAEn(busAEn), .busB(busB), .busBEn(busBEn),
    .latchClk(latchClk), .latchClkN(latchClkN), .latchEn(latchEn)
  );

  task automatic chk(input string req, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int codeOf(input int j, input bit chB);
    logic [2*CW-1:0] v;
    v = VEC[j % 8];
    return chB ? int'(v[CW-1:0]) : int'(v[2*CW-1:CW]);
  endfunction

  // expected bus A value after edge e (edge 1 = first after reset)
  function automatic int expBusA(input bit m, input bit s, input int e);
    bit fast;
    int lat, d;
    fast = !(m && !s);
    if (s) begin
      d = e - 9;
      if (d < 0) return 0;
      return (d % 2 == 0) ? codeOf(d / 2, 1'b0) : codeOf((d - 1) / 2, 1'b1);
    end
    lat = fast ? 8 : 4;
    d = e - 1 - lat;
    if (d < 0) return 0;
    return codeOf(fast ? d / 2 : d, 1'b0);
  endfunction

  function automatic int expBusB(input bit m, input bit s, input int e);
    bit fast;
    int lat, d;
    if (s) return 0;
    fast = !m;
    lat = fast ? 8 : 4;
    d = e - 1 - lat;
    if (d < 0) return 0;
    return codeOf(fast ? d / 2 : d, 1'b1);
  endfunction

  function automatic int expLatch(input bit m, input bit s, input int e);
    if (m && s) return e % 2;
    if (!m || s) return ((e + 1) / 2) % 2;
    return e % 2;
  endfunction

  task automatic runMode(input bit m, input bit s, input string tagA);
    modeSel = m; singleBus = s; outEnN = 1'b0; standby = 1'b0;
    rstN = 1'b0; codeA = '0; codeB = '0;
    repeat (2) @(negedge clk);
    // R1 reset state
    chk("R1 busA", int'(busA), 0);
    chk("R1 busB", int'(busB), 0);
    chk("R1 latchClk", int'(latchClk), 0);
    chk("R1 latchClkN", int'(latchClkN), 1);
    rstN = 1'b1;
    for (int e = 1; e <= 40; e++) begin
      int j;
      j = (!(m && !s)) ? (e - 1) / 2 : e - 1;
      codeA = CW'(codeOf(j, 1'b0));
      codeB = CW'(codeOf(j, 1'b1));
      @(negedge clk);
      chk(tagA, int'(busA), expBusA(m, s, e));
      if (s) begin
        chk("R5 busB", int'(busB), 0);
        chk("R5 busBEn", int'(busBEn), 0);
      end else begin
        chk({tagA, " busB"}, int'(busB), expBusB(m, s, e));
        chk("R5 busBEn", int'(busBEn), 1);
      end
      chk((m && s) ? "R6 latchClk" : "R7 latchClk", int'(latchClk), expLatch(m, s, e));
      chk("R8 latchClkN", int'(latchClkN), 1 - expLatch(m, s, e));
    end
  endtask

  initial begin
    #(20 * 200000);
    if (!finished) begin
      nFails++;
      nChecks++;
      $display("FAIL watchdog: actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    runMode(1'b0, 1'b0, "R2 busA");
    runMode(1'b1, 1'b0, "R3 busA");
    runMode(1'b0, 1'b1, "R4 busA");
    runMode(1'b1, 1'b1, "R4 busA");

    // directed: asynchronous output enable (R9), dual-bus slow mode
    runMode(1'b1, 1'b0, "R3 busA");
    #3 outEnN = 1'b1;
    #1;
    chk("R9 busAEn", int'(busAEn), 0);
    chk("R9 busBEn", int'(busBEn), 0);
    chk("R9 latchEn", int'(latchEn), 0);
    chk("R9 busA", int'(busA), 0);
    chk("R8 idle latch", int'(latchClk | latchClkN), 0);
    outEnN = 1'b0;
    #1;
    chk("R9 busAEn back", int'(busAEn), 1);
    chk("R9 busBEn back", int'(busBEn), 1);
    chk("R9 latchEn back", int'(latchEn), 1);

    // directed: standby (R10) with output enable asserted
    standby = 1'b1;
    #1;
    chk("R10 busAEn", int'(busAEn), 0);
    chk("R10 busBEn", int'(busBEn), 0);
    chk("R10 latchEn", int'(latchEn), 0);
    chk("R10 busB", int'(busB), 0);
    standby = 1'b0;
    #1;
    chk("R10 busAEn back", int'(busAEn), 1);

    // directed: reset mid-run returns to cleared state (R1)
    @(negedge clk);
    rstN = 1'b0;
    @(negedge clk);
    chk("R1 busA rerun", int'(busA), 0);
    chk("R1 latchClk rerun", int'(latchClk), 0);

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule